// File: doc/BRIEF.md
# Real-Time Counter with Staged Configuration

This block keeps time as a 32-bit seconds-style counter advanced by a programmable 20-bit prescaler. The prescaler counts down on each pulse of a tick-enable input. Each rollover raises a periodic event flag. The counter is compared against an alarm value, and it raises a separate flag when it wraps. A small register interface lets software read the counter, the alarm, the prescaler reload value and the current divider. The same interface lets software clear flags and change the time base.

Changes to the time base go through a configuration handshake. Software sets a configuration bit in the control/status register and writes new counter, alarm or reload values. These values are only staged. When software clears the configuration bit, the block enters a commit phase that lasts a fixed number of tick periods. During that phase a write-complete bit reads 0 and every bus write is dropped. At the end of the phase the staged values replace the live ones, and the write-complete bit returns to 1.

Software reads the counter and divider through copies. These copies are refreshed one clock after every tick. A synchronized flag tells software that a fresh copy has landed. The interrupt enables are inputs. A single interrupt output combines the enabled events.

The control FSM has three states:
- ST_RUN: normal operation, writes to staged registers dropped. It moves to ST_CONFIG on a control write with the configuration bit at 1.
- ST_CONFIG: staging allowed. It moves to ST_COMMIT on a control write with the configuration bit at 0.
- ST_COMMIT: busy, all writes dropped. It moves back to ST_RUN on the third tick pulse, and that same edge applies the staged values.

Top module: `rtc_counter_top`

## Requirements
- R1: After reset, the control/status register (address 0) reads 0x0020, the counter reads 0, and `irq` is 0.
- R2: In the control/status register, bits 15:6 always read 0 and take no writes. Writing 1 to any flag bit (bits 3:0) leaves that flag unchanged.
- R3: The counter (address 2), alarm (address 3) and prescaler reload (address 1) accept writes only while the configuration bit (bit 4) is 1. Writes made in normal operation are dropped.
- R4: Staged values reach the live registers only after software writes bit 4 back to 0. Bit 5 then reads 0 for 3 tick pulses. The live registers change on the edge of the third pulse, and bit 5 reads 1 from that point.
- R5: While bit 5 reads 0, every bus write is dropped. This includes writes to the control/status register, whether they set the configuration bit or clear flags.
- R6: The prescaler divider counts down once per tick. When the divider is 0, the tick reloads it from the reload register, increments the counter, and sets the second flag (bit 0). The counter therefore advances once every reload+1 ticks. A committed reload value is also loaded straight into the divider.
- R7: When an increment brings the counter to the alarm value, the alarm flag (bit 1) is set.
- R8: When an increment takes the counter from 0xFFFFFFFF to 0, the overflow flag (bit 2) is set.
- R9: Reads of the counter and of the divider (address 4) return copies refreshed on the clock after each tick. The synchronized flag (bit 3) is set on each refresh.
- R10: Writing 0 to a flag bit clears that flag. When a hardware set and a software clear of the same flag happen in the same cycle, the flag ends up set.
- R11: `irq` is the OR of (second flag AND `ie_sec`), (alarm flag AND `ie_alarm`) and (overflow flag AND `ie_ovf`). The synchronized flag never drives `irq`.
- R12: Register map for reads and writes: 0 control/status, 1 prescaler reload, 2 counter, 3 alarm, 4 divider (read-only). Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse that advances the prescaler |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address, used for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ie_sec | input | 1 | Enables the second-flag interrupt |
| ie_alarm | input | 1 | Enables the alarm-flag interrupt |
| ie_ovf | input | 1 | Enables the overflow-flag interrupt |
| irq | output | 1 | Combined interrupt |

## Verification
The overflow flag is the hardest event to reach from the ports. Counting up to 2^32 is out of reach, so the stimulus uses the configuration handshake to stage a counter value of 0xFFFFFFFE with a reload of 0. After the commit, two ticks produce the wrap. A second delicate case is a flag clear that arrives in the same cycle as the event that sets the flag. The bench raises the tick pulse and the clearing write on the same falling edge, so both take effect at one rising edge. The busy window is probed with writes that would otherwise clear a flag or re-enter configuration.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_RELOAD = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_COUNT  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_ALARM  = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_DIVIDE = 3'd4;

    // flag positions inside the control/status register
    localparam int FLAG_SEC  = 0;
    localparam int FLAG_ALM  = 1;
    localparam int FLAG_OVF  = 2;
    localparam int FLAG_SYNC = 3;
    localparam int NUM_FLAGS = 4;
    localparam int BIT_CFG   = 4;
    localparam int BIT_DONE  = 5;
    localparam int CTRL_W    = 16;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_CONFIG,
        ST_COMMIT
    } cfg_state_t;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int                 DIV_W       = 20,
    parameter logic [DIV_W-1:0]   RELOAD_INIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load_en,
    input  logic [DIV_W-1:0] load_val,
    input  logic [DIV_W-1:0] reload,
    output logic [DIV_W-1:0] div_o,
    output logic             inc_o
);

    localparam logic [DIV_W-1:0] DIV_ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] div_q;

    assign inc_o = tick_en && (div_q == '0) && !load_en;
    assign div_o = div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= RELOAD_INIT;
        end else if (load_en) begin
            div_q <= load_val;
        end else if (tick_en) begin
            if (div_q == '0) begin
                div_q <= reload;
            end else begin
                div_q <= div_q - DIV_ONE;
            end
        end
    end

    // R6: a rollover leaves the divider at the reload value
    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inc_o |=> (div_q == $past(reload)));

endmodule

// File: rtl/rtc_cfg_fsm.sv
module rtc_cfg_fsm
    import rtc_pkg::*;
#(
    parameter int COMMIT_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic ctrl_wr,
    input  logic cfg_bit,
    output logic cfg_mode,
    output logic wr_done,
    output logic commit_o
);

    localparam int TCNT_W = $clog2(COMMIT_TICKS + 1);
    localparam logic [TCNT_W-1:0] TCNT_LAST = TCNT_W'(COMMIT_TICKS - 1);
    localparam logic [TCNT_W-1:0] TCNT_ONE  = TCNT_W'(1);

    cfg_state_t        state_q, state_d;
    logic [TCNT_W-1:0] tcnt_q;
    logic              last_tick;

    assign last_tick = tick_en && (tcnt_q == TCNT_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (ctrl_wr && cfg_bit)  state_d = ST_CONFIG;
            ST_CONFIG: if (ctrl_wr && !cfg_bit) state_d = ST_COMMIT;
            ST_COMMIT: if (last_tick)           state_d = ST_RUN;
            default:                            state_d = ST_RUN;
        endcase
    end

    // state register and commit tick counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            tcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_COMMIT) begin
                tcnt_q <= '0;
            end else if (tick_en) begin
                tcnt_q <= tcnt_q + TCNT_ONE;
            end
        end
    end

    // outputs
    always_comb begin
        cfg_mode = 1'b0;
        wr_done  = 1'b1;
        commit_o = 1'b0;
        unique case (state_q)
            ST_RUN:    ;
            ST_CONFIG: cfg_mode = 1'b1;
            ST_COMMIT: begin
                wr_done  = 1'b0;
                commit_o = last_tick;
            end
            default:   ;
        endcase
    end

    // R5: nothing but a tick can end the busy phase
    assert_busy_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT && !tick_en) |=> (state_q == ST_COMMIT));

    // R4: write-complete returns only after the commit edge
    assert_done_after_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_done && !commit_o) |=> !wr_done);

endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
    parameter int NFLAG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_i,
    input  logic             clr_wr,
    input  logic [NFLAG-1:0] wdata,
    output logic [NFLAG-1:0] flags_o
);

    logic [NFLAG-1:0] flag_q;

    assign flags_o = flag_q;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        logic clear_req;
        assign clear_req = clr_wr && !wdata[i];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else begin
                flag_q[i] <= set_i[i] || (flag_q[i] && !clear_req);
            end
        end

        // R10: a hardware set is never lost to a same-cycle clear
        assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_q[i]);
    end

endmodule

// File: rtl/rtc_counter_top.sv
module rtc_counter_top
    import rtc_pkg::*;
#(
    parameter int                CNT_W        = 32,
    parameter int                DIV_W        = 20,
    parameter int                COMMIT_TICKS = 3,
    parameter logic [DIV_W-1:0]  RELOAD_INIT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              ie_sec,
    input  logic              ie_alarm,
    input  logic              ie_ovf,
    output logic              irq
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // live, staged and shadow state
    logic [CNT_W-1:0] cnt_q, alarm_q, cnt_shadow_q;
    logic [DIV_W-1:0] reload_q, div_shadow_q;
    logic [CNT_W-1:0] stg_cnt_q, stg_alarm_q;
    logic [DIV_W-1:0] stg_reload_q;
    logic             pend_cnt_q, pend_alarm_q, pend_reload_q;
    logic             tick_d_q;

    // control
    logic             cfg_mode, wr_done, commit;
    logic             wr_ok, ctrl_wr, stage_wr;
    logic [DIV_W-1:0] div_now;
    logic             inc, cnt_step;
    logic [CNT_W-1:0] cnt_plus;
    logic [NUM_FLAGS-1:0] flag_set, flags;
    logic [CTRL_W-1:0] ctrl_rd;

    assign wr_ok    = bus_wr && wr_done;
    assign ctrl_wr  = wr_ok && (bus_addr == ADDR_CTRL);
    assign stage_wr = wr_ok && cfg_mode;

    rtc_cfg_fsm #(
        .COMMIT_TICKS (COMMIT_TICKS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .ctrl_wr  (ctrl_wr),
        .cfg_bit  (bus_wdata[BIT_CFG]),
        .cfg_mode (cfg_mode),
        .wr_done  (wr_done),
        .commit_o (commit)
    );

    rtc_prescaler #(
        .DIV_W       (DIV_W),
        .RELOAD_INIT (RELOAD_INIT)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load_en  (commit && pend_reload_q),
        .load_val (stg_reload_q),
        .reload   (reload_q),
        .div_o    (div_now),
        .inc_o    (inc)
    );

    // counter step is suppressed when a committed value overrides it
    assign cnt_step = inc && !(commit && pend_cnt_q);
    assign cnt_plus = cnt_q + CNT_ONE;

    always_comb begin
        flag_set            = '0;
        flag_set[FLAG_SEC]  = cnt_step;
        flag_set[FLAG_ALM]  = cnt_step && (cnt_plus == alarm_q);
        flag_set[FLAG_OVF]  = cnt_step && (cnt_q == CNT_MAX);
        flag_set[FLAG_SYNC] = tick_d_q;
    end

    rtc_flag_bank #(
        .NFLAG (NUM_FLAGS)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (flag_set),
        .clr_wr  (ctrl_wr),
        .wdata   (bus_wdata[NUM_FLAGS-1:0]),
        .flags_o (flags)
    );

    // staging registers, written only in configuration mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_cnt_q     <= '0;
            stg_alarm_q   <= '0;
            stg_reload_q  <= '0;
            pend_cnt_q    <= 1'b0;
            pend_alarm_q  <= 1'b0;
            pend_reload_q <= 1'b0;
        end else if (commit) begin
            pend_cnt_q    <= 1'b0;
            pend_alarm_q  <= 1'b0;
            pend_reload_q <= 1'b0;
        end else if (stage_wr) begin
            unique case (bus_addr)
                ADDR_COUNT: begin
                    stg_cnt_q  <= bus_wdata;
                    pend_cnt_q <= 1'b1;
                end
                ADDR_ALARM: begin
                    stg_alarm_q  <= bus_wdata;
                    pend_alarm_q <= 1'b1;
                end
                ADDR_RELOAD: begin
                    stg_reload_q  <= bus_wdata[DIV_W-1:0];
                    pend_reload_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // live registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            alarm_q  <= '0;
            reload_q <= RELOAD_INIT;
        end else begin
            if (commit && pend_cnt_q) begin
                cnt_q <= stg_cnt_q;
            end else if (cnt_step) begin
                cnt_q <= cnt_plus;
            end
            if (commit && pend_alarm_q) begin
                alarm_q <= stg_alarm_q;
            end
            if (commit && pend_reload_q) begin
                reload_q <= stg_reload_q;
            end
        end
    end

    // readable copies refreshed on the clock after each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_d_q     <= 1'b0;
            cnt_shadow_q <= '0;
            div_shadow_q <= RELOAD_INIT;
        end else begin
            tick_d_q <= tick_en;
            if (tick_d_q) begin
                cnt_shadow_q <= cnt_q;
                div_shadow_q <= div_now;
            end
        end
    end

    // read mux
    always_comb begin
        ctrl_rd                    = '0;
        ctrl_rd[NUM_FLAGS-1:0]     = flags;
        ctrl_rd[BIT_CFG]           = cfg_mode;
        ctrl_rd[BIT_DONE]          = wr_done;
        case (bus_addr)
            ADDR_CTRL:   bus_rdata = CNT_W'(ctrl_rd);
            ADDR_RELOAD: bus_rdata = CNT_W'(reload_q);
            ADDR_COUNT:  bus_rdata = cnt_shadow_q;
            ADDR_ALARM:  bus_rdata = alarm_q;
            ADDR_DIVIDE: bus_rdata = CNT_W'(div_shadow_q);
            default:     bus_rdata = '0;
        endcase
    end

    assign irq = (flags[FLAG_SEC] && ie_sec)
              || (flags[FLAG_ALM] && ie_alarm)
              || (flags[FLAG_OVF] && ie_ovf);

    // R8: an overflow event leaves the counter at zero
    assert_wrap_to_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set[FLAG_OVF] |=> (cnt_q == '0));

    // R7: an alarm event leaves the counter equal to the alarm value
    assert_alarm_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set[FLAG_ALM] && !commit) |=> (cnt_q == alarm_q));

    // R3: live alarm changes only on a commit edge
    assert_alarm_only_on_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(alarm_q));

    // R11: the synchronized flag alone never raises the interrupt
    assert_sync_no_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLAG_SEC] == 1'b0 && flags[FLAG_ALM] == 1'b0 && flags[FLAG_OVF] == 1'b0) |-> !irq);

endmodule

// File: tb/sim_rtc_counter_top.sv
`timescale 1ns/1ps
module sim_rtc_counter_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ie_sec = 1'b0, ie_alarm = 1'b0, ie_ovf = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    rtc_counter_top u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ie_sec(ie_sec), .ie_alarm(ie_alarm),
        .ie_ovf(ie_ovf), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    // stage reload/count/alarm, exit, wait the commit, clear all flags
    task automatic configure(input logic [31:0] rl, input logic [31:0] c, input logic [31:0] al);
        wr(3'd0, 32'h10);
        wr(3'd1, rl);
        wr(3'd2, c);
        wr(3'd3, al);
        wr(3'd0, 32'h00);
        repeat (3) tick();
        @(negedge clk);
        wr(3'd0, 32'h00);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); check("R1 ctrl reset", v, 32'h20);
        rd(3'd2, v); check("R1 counter reset", v, 32'h0);
        check("R1 irq reset", {31'b0, irq}, 32'h0);
        rd(3'd6, v); check("R12 unmapped address", v, 32'h0);
    endtask

    task automatic t_config_commit();
        logic [31:0] v;
        wr(3'd3, 32'd77);
        rd(3'd3, v); check("R3 alarm write in run dropped", v, 32'h0);
        wr(3'd0, 32'h10);
        rd(3'd0, v); check("R4 config bit reads 1", v, 32'h30);
        wr(3'd2, 32'd100);
        tick();
        rd(3'd2, v); check("R4 staged counter not live", v, 32'h0);
        wr(3'd0, 32'h00);
        rd(3'd0, v); check("R4 busy after exit", v & 32'h30, 32'h0);
        wr(3'd3, 32'd5);   // dropped: busy
        tick(); tick();
        rd(3'd0, v); check("R4 busy after two ticks", v & 32'h20, 32'h0);
        tick();
        rd(3'd0, v); check("R4 done after third tick", v & 32'h30, 32'h20);
        rd(3'd2, v); check("R4 counter committed", v, 32'd100);
        rd(3'd3, v); check("R5 alarm write while busy dropped", v, 32'h0);
    endtask

    task automatic t_prescaler();
        logic [31:0] v;
        configure(32'd2, 32'd10, 32'hFFFF_0000);
        rd(3'd4, v); check("R12 divider read", v, 32'd2);
        rd(3'd1, v); check("R12 reload read", v, 32'd2);
        tick(); tick();
        rd(3'd2, v); check("R6 no step before reload+1 ticks", v, 32'd10);
        rd(3'd0, v); check("R6 second flag clear", v & 32'h1, 32'h0);
        tick();
        rd(3'd2, v); check("R6 step on third tick", v, 32'd11);
        rd(3'd0, v); check("R6 second flag set", v, 32'h29);
        check("R11 masked second flag", {31'b0, irq}, 32'h0);
        ie_sec = 1'b1;
        #1 check("R11 enabled second flag", {31'b0, irq}, 32'h1);
        wr(3'd0, 32'hFFEF);
        rd(3'd0, v); check("R2 write ones no effect", v, 32'h29);
        wr(3'd0, 32'h0E);
        rd(3'd0, v); check("R10 write zero clears second flag", v, 32'h28);
        check("R11 irq drops", {31'b0, irq}, 32'h0);
        ie_sec = 1'b0;
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        tick(); tick();   // divider now 0
        @(negedge clk);
        tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h0;
        @(negedge clk);
        tick_en = 1'b0; bus_wr = 1'b0;
        rd(3'd0, v); check("R10 set wins over clear", v & 32'h7, 32'h1);
        rd(3'd2, v); check("R6 counter after set-wins tick", v, 32'd12);
    endtask

    task automatic t_alarm();
        logic [31:0] v;
        configure(32'd0, 32'd20, 32'd22);
        tick();
        rd(3'd0, v); check("R7 no alarm at 21", v & 32'h2, 32'h0);
        tick();
        rd(3'd2, v); check("R7 counter at 22", v, 32'd22);
        rd(3'd0, v); check("R7 alarm flag set", v & 32'h2, 32'h2);
        ie_alarm = 1'b1;
        #1 check("R11 alarm irq", {31'b0, irq}, 32'h1);
        tick();
        rd(3'd0, v); check("R7 alarm flag sticky", v & 32'h2, 32'h2);
        ie_alarm = 1'b0;
        #1 check("R11 alarm masked", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        configure(32'd0, 32'hFFFF_FFFE, 32'd5);
        tick();
        rd(3'd2, v); check("R8 counter at max", v, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R8 no overflow yet", v & 32'h4, 32'h0);
        tick();
        rd(3'd2, v); check("R8 counter wrapped", v, 32'h0);
        rd(3'd0, v); check("R8 overflow flag set", v & 32'h4, 32'h4);
        ie_ovf = 1'b1;
        #1 check("R11 overflow irq", {31'b0, irq}, 32'h1);
        wr(3'd0, 32'h14);
        wr(3'd0, 32'h04);
        wr(3'd0, 32'h10);  // dropped: busy
        wr(3'd0, 32'h00);  // dropped: busy
        rd(3'd0, v); check("R5 ctrl writes dropped while busy", v & 32'h34, 32'h04);
        repeat (3) tick();
        rd(3'd0, v); check("R5 overflow kept through busy", v & 32'h34, 32'h24);
        wr(3'd0, 32'h00);
        rd(3'd0, v); check("R10 overflow cleared", v & 32'h4, 32'h0);
        check("R11 irq after clear", {31'b0, irq}, 32'h0);
        ie_ovf = 1'b0;
    endtask

    task automatic t_sync();
        logic [31:0] v;
        wr(3'd0, 32'h00);
        rd(3'd0, v); check("R9 sync flag cleared", v & 32'h8, 32'h0);
        tick();
        rd(3'd0, v); check("R9 sync flag set after tick", v & 32'h8, 32'h8);
        check("R11 sync flag no irq", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_config_commit();
        t_prescaler();
        t_set_wins();
        t_alarm();
        t_overflow();
        t_sync();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule